// File: doc/BRIEF.md
# Windowed Register File with Call/Return Window Shifting

This block is the integer register file of a 32-bit load/store core in which procedure calls do not save registers through memory. The core always addresses 32 architectural registers with 5-bit numbers. The block translates each number onto a larger physical array through a current-window pointer. The lowest ten architectural numbers are shared by all procedures. The remaining 22 belong to the active window, and neighbouring windows overlap so that arguments pass between caller and callee without any copying.

The core presents two combinational read addresses and one write port that commits on the rising clock edge. A one-cycle `win_call` pulse steps the window forward and a one-cycle `win_ret` pulse steps it back. A count of live windows is kept. A call that finds every window live is refused and raises `win_ovf` for one cycle. A return that finds only the current window live is refused and raises `win_unf` for one cycle. Saving windows to memory and restoring them is left to the trap logic that watches these flags.

Top module: `rwin_file`

## Requirements
- R1: Architectural numbers 1 to 9 are shared. A value written through any of them in one window reads back unchanged in every other window.
- R2: Architectural register 0 always reads as zero on both read ports. A write to register 0 changes no register.
- R3: The 22 windowed numbers fall into three groups. The outgoing group is 10–15, the local group is 16–25 and the incoming group is 26–31. Window w places incoming register k at physical 10 + (16w + k) mod 128, local register k at physical 10 + (16w + 6 + k) mod 128, and outgoing register k at physical 10 + (16w + 16 + k) mod 128. As a result, outgoing register 10+k of window w is the same storage as incoming register 26+k of window (w+1) mod 8.
- R4: An accepted call increments `win_ptr` modulo 8. An accepted return decrements it modulo 8. Both take effect on the clock edge that samples the pulse.
- R5: When call and return are asserted in the same cycle, neither takes effect. The pointer holds and no flag is raised.
- R6: When all 8 windows are live, a call leaves `win_ptr` unchanged and asserts `win_ovf`.
- R7: When only the current window is live, a return leaves `win_ptr` unchanged and asserts `win_unf`.
- R8: A write in the same cycle as a call or return is translated with the pointer value held before that edge.
- R9: Reads are not bypassed. During a cycle in which a register is being written, a read of that register returns its previous contents.
- R10: Synchronous reset sets `win_ptr` to 0 and the live count to one window. Register contents are kept.
- R11: `win_ovf` and `win_unf` are registered. Each is high for exactly the one cycle after the refused request and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Architectural number for read port A |
| rd_data_a | output | 32 | Read port A data, combinational |
| rd_addr_b | input | 5 | Architectural number for read port B |
| rd_data_b | output | 32 | Read port B data, combinational |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural number to write |
| wr_data | input | 32 | Write data |
| win_call | input | 1 | Request to move to the next window |
| win_ret | input | 1 | Request to move to the previous window |
| win_ptr | output | 5 | Current window pointer, 0 to 7 |
| win_ovf | output | 1 | Call refused because all windows are live |
| win_unf | output | 1 | Return refused because only one window is live |

## Verification
The bench walks the pointer through all eight windows. In each window it writes every writable register and reads all 32 numbers on both ports, then walks back down and re-reads them against a mapping it computes itself. In that walk a wrong window stride or a missing modulo-128 wrap shows up as stale data, most visibly where window 7's outgoing group lands on window 0's incoming group. It pushes the call and return pulses against both ends of the live count: a design that fails to refuse would move the pointer past 7 or below 0, and a design with sticky flags would keep them high a second cycle. It also combines a write with a window move, a read of a register under write, and a reset with registers still holding data. These catch translation through the new pointer, an unwanted forwarding path, and a reset that wipes contents or leaves the live count stale.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  // Requested window movement for one cycle
  typedef enum logic [1:0] {
    MV_HOLD = 2'd0,
    MV_ADV  = 2'd1,
    MV_BACK = 2'd2
  } win_move_e;
endpackage

// File: rtl/rwin_map.sv
// Architectural-to-physical register translation for one port.
module rwin_map #(
  parameter int N_GLOB = 10,
  parameter int N_OUT  = 6,
  parameter int N_LOC  = 10,
  parameter int N_IN   = 6,
  parameter int NWIN   = 8,
  parameter int AW     = 5,
  parameter int CW     = 5,
  parameter int PW     = 8
) (
  input  logic [AW-1:0] arch,
  input  logic [CW-1:0] ptr,
  output logic [PW-1:0] phys
);
  localparam int STRIDE = N_IN + N_LOC;
  localparam int WREGS  = NWIN * STRIDE;
  localparam int LOC0   = N_GLOB + N_OUT;
  localparam int IN0    = LOC0 + N_LOC;

  int a_i;
  int off;
  int slot;

  always_comb begin
    a_i = int'(arch);
    if (a_i >= IN0)       off = a_i - IN0;
    else if (a_i >= LOC0) off = N_IN + (a_i - LOC0);
    else                  off = STRIDE + (a_i - N_GLOB);
    slot = (int'(ptr) * STRIDE + off) % WREGS;
    if (a_i < N_GLOB) phys = PW'(a_i);
    else              phys = PW'(N_GLOB + slot);
  end
endmodule

// File: rtl/rwin_ptr.sv
// Current-window pointer, live-window count and refusal flags.
module rwin_ptr
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = 5,
  parameter int LW   = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          call_i,
  input  logic          ret_i,
  output logic [CW-1:0] ptr_q,
  output logic [LW-1:0] saved_q,
  output logic          ovf_q,
  output logic          unf_q
);
  localparam logic [CW-1:0] PTR_TOP  = CW'(NWIN - 1);
  localparam logic [LW-1:0] SAVE_TOP = LW'(NWIN - 1);

  win_move_e     mv;
  logic          full;
  logic          empty;
  logic [CW-1:0] ptr_nxt;
  logic [CW-1:0] ptr_prv;

  always_comb begin
    if (call_i && !ret_i)      mv = MV_ADV;
    else if (ret_i && !call_i) mv = MV_BACK;
    else                       mv = MV_HOLD;
  end

  assign full    = (saved_q == SAVE_TOP);
  assign empty   = (saved_q == '0);
  assign ptr_nxt = (ptr_q == PTR_TOP) ? '0 : ptr_q + 1'b1;
  assign ptr_prv = (ptr_q == '0) ? PTR_TOP : ptr_q - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      saved_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      case (mv)
        MV_ADV: begin
          if (full) ovf_q <= 1'b1;
          else begin
            ptr_q   <= ptr_nxt;
            saved_q <= saved_q + 1'b1;
          end
        end
        MV_BACK: begin
          if (empty) unf_q <= 1'b1;
          else begin
            ptr_q   <= ptr_prv;
            saved_q <= saved_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rwin_store.sv
// Physical register array: one write port, two asynchronous read ports.
module rwin_store #(
  parameter int DW    = 32,
  parameter int NPHYS = 138,
  parameter int PW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [PW-1:0] ra0,
  output logic [DW-1:0] rd0,
  input  logic [PW-1:0] ra1,
  output logic [DW-1:0] rd1
);
  logic [DW-1:0] mem [NPHYS];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/rwin_file.sv
// Top: windowed register file.
module rwin_file #(
  parameter int DW     = 32,
  parameter int AW     = 5,
  parameter int CW     = 5,
  parameter int NWIN   = 8,
  parameter int N_GLOB = 10,
  parameter int N_OUT  = 6,
  parameter int N_LOC  = 10,
  parameter int N_IN   = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr_a,
  output logic [DW-1:0] rd_data_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          win_call,
  input  logic          win_ret,
  output logic [CW-1:0] win_ptr,
  output logic          win_ovf,
  output logic          win_unf
);
  localparam int NPHYS = N_GLOB + NWIN * (N_IN + N_LOC);
  localparam int PW    = $clog2(NPHYS);
  localparam int LW    = $clog2(NWIN);
  localparam int NPORT = 3;  // read A, read B, write

  logic [LW-1:0] saved_cnt;
  logic [AW-1:0] arch_v [NPORT];
  logic [PW-1:0] phys_v [NPORT];
  logic [DW-1:0] raw_a;
  logic [DW-1:0] raw_b;

  assign arch_v[0] = rd_addr_a;
  assign arch_v[1] = rd_addr_b;
  assign arch_v[2] = wr_addr;

  rwin_ptr #(.NWIN(NWIN), .CW(CW), .LW(LW)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .call_i  (win_call),
    .ret_i   (win_ret),
    .ptr_q   (win_ptr),
    .saved_q (saved_cnt),
    .ovf_q   (win_ovf),
    .unf_q   (win_unf)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rwin_map #(
      .N_GLOB(N_GLOB), .N_OUT(N_OUT), .N_LOC(N_LOC), .N_IN(N_IN),
      .NWIN(NWIN), .AW(AW), .CW(CW), .PW(PW)
    ) u_map (
      .arch (arch_v[p]),
      .ptr  (win_ptr),
      .phys (phys_v[p])
    );
  end

  rwin_store #(.DW(DW), .NPHYS(NPHYS), .PW(PW)) u_store (
    .clk (clk),
    .we  (wr_en && (wr_addr != '0)),
    .wa  (phys_v[2]),
    .wd  (wr_data),
    .ra0 (phys_v[0]),
    .rd0 (raw_a),
    .ra1 (phys_v[1]),
    .rd1 (raw_b)
  );

  assign rd_data_a = (rd_addr_a == '0) ? '0 : raw_a;
  assign rd_data_b = (rd_addr_b == '0) ? '0 : raw_b;
endmodule

// File: rtl/rwin_file_chk.sv
// Property checker attached to the windowed register file.
module rwin_file_chk #(
  parameter int DW   = 32,
  parameter int AW   = 5,
  parameter int CW   = 5,
  parameter int NWIN = 8,
  parameter int LW   = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          win_call,
  input logic          win_ret,
  input logic [CW-1:0] win_ptr,
  input logic          win_ovf,
  input logic          win_unf,
  input logic [LW-1:0] saved_cnt,
  input logic [AW-1:0] rd_addr_a,
  input logic [DW-1:0] rd_data_a,
  input logic [AW-1:0] rd_addr_b,
  input logic [DW-1:0] rd_data_b
);
  localparam logic [LW-1:0] SAVE_TOP = LW'(NWIN - 1);

  a_r4_call_adv: assert property (@(posedge clk) disable iff (rst)
    (win_call && !win_ret && saved_cnt != SAVE_TOP)
      |=> int'(win_ptr) == (int'($past(win_ptr)) + 1) % NWIN);

  a_r4_ret_back: assert property (@(posedge clk) disable iff (rst)
    (win_ret && !win_call && saved_cnt != '0)
      |=> int'(win_ptr) == (int'($past(win_ptr)) + NWIN - 1) % NWIN);

  a_r5_both_ignored: assert property (@(posedge clk) disable iff (rst)
    (win_call && win_ret) |=> $stable(win_ptr) && !win_ovf && !win_unf);

  a_r6_overflow: assert property (@(posedge clk) disable iff (rst)
    (win_call && !win_ret && saved_cnt == SAVE_TOP) |=> win_ovf && $stable(win_ptr));

  a_r7_underflow: assert property (@(posedge clk) disable iff (rst)
    (win_ret && !win_call && saved_cnt == '0) |=> win_unf && $stable(win_ptr));

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (win_call == win_ret) |=> !win_ovf && !win_unf);

  a_r2_zero_a: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == '0) |-> rd_data_a == '0);

  a_r2_zero_b: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_b == '0) |-> rd_data_b == '0);
endmodule

bind rwin_file rwin_file_chk #(
  .DW(DW), .AW(AW), .CW(CW), .NWIN(NWIN), .LW(LW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .win_call  (win_call),
  .win_ret   (win_ret),
  .win_ptr   (win_ptr),
  .win_ovf   (win_ovf),
  .win_unf   (win_unf),
  .saved_cnt (saved_cnt),
  .rd_addr_a (rd_addr_a),
  .rd_data_a (rd_data_a),
  .rd_addr_b (rd_addr_b),
  .rd_data_b (rd_data_b)
);

// File: tb/test_rwin_file.sv
`timescale 1ns/1ps
module test_rwin_file;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_addr_a = '0;
  logic [31:0] rd_data_a;
  logic [4:0]  rd_addr_b = '0;
  logic [31:0] rd_data_b;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        win_call = 1'b0;
  logic        win_ret = 1'b0;
  logic [4:0]  win_ptr;
  logic        win_ovf;
  logic        win_unf;

  int n_chk = 0;
  int n_bad = 0;
  int cwp_m = 0;
  int live_m = 1;
  logic [31:0] mdl [138];

  always #5 clk = ~clk;

  rwin_file i_rwin_file (
    .clk(clk), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .win_call(win_call), .win_ret(win_ret),
    .win_ptr(win_ptr), .win_ovf(win_ovf), .win_unf(win_unf)
  );

  function automatic int pmap(int a, int w);
    int off;
    if (a < 10) return a;
    if (a >= 26)      off = a - 26;
    else if (a >= 16) off = 6 + (a - 16);
    else              off = 16 + (a - 10);
    return 10 + (w * 16 + off) % 128;
  endfunction

  function automatic logic [31:0] pat(int w, int a, int s);
    return 32'h5A00_0000 | (32'(s) << 16) | (32'(w) << 8) | 32'(a);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_write(int a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    tick();
    wr_en = 1'b0;
    if (a != 0) mdl[pmap(a, cwp_m)] = d;
  endtask

  // Apply one cycle of call/return and update the model.
  task automatic do_move(logic c, logic r);
    logic eo, eu;
    eo = 1'b0; eu = 1'b0;
    win_call = c; win_ret = r;
    tick();
    win_call = 1'b0; win_ret = 1'b0;
    if (c && !r) begin
      if (live_m == 8) eo = 1'b1;
      else begin cwp_m = (cwp_m + 1) % 8; live_m++; end
    end else if (r && !c) begin
      if (live_m == 1) eu = 1'b1;
      else begin cwp_m = (cwp_m + 7) % 8; live_m--; end
    end
    chk("R4 pointer", 32'(win_ptr), 32'(cwp_m));
    chk("R6 overflow flag", 32'(win_ovf), 32'(eo));
    chk("R7 underflow flag", 32'(win_unf), 32'(eu));
  endtask

  task automatic read_all(string req);
    for (int a = 0; a < 32; a++) begin
      rd_addr_a = 5'(a);
      rd_addr_b = 5'(31 - a);
      #1;
      chk(req, rd_data_a, (a == 0) ? 32'h0 : mdl[pmap(a, cwp_m)]);
      chk(req, rd_data_b, (a == 31) ? 32'h0 : mdl[pmap(31 - a, cwp_m)]);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] keep;
    tick(); tick();
    rst = 1'b0;
    // R10: reset state
    chk("R10 reset ptr", 32'(win_ptr), 32'd0);
    chk("R11 reset ovf", 32'(win_ovf), 32'd0);
    chk("R11 reset unf", 32'(win_unf), 32'd0);

    // Upward sweep: fill every window, read everything (R1, R3, R4)
    for (int w = 0; w < 8; w++) begin
      for (int a = 1; a < 32; a++) do_write(a, pat(w, a, 1));
      read_all("R3 upward sweep");
      if (w < 7) do_move(1'b1, 1'b0);
    end

    // R6: call with all windows live is refused, flag lasts one cycle (R11)
    do_move(1'b1, 1'b0);
    chk("R6 ptr held at 7", 32'(win_ptr), 32'd7);
    tick();
    chk("R11 ovf drops", 32'(win_ovf), 32'd0);

    // Downward sweep with re-read (R3 overlap and wrap)
    for (int w = 6; w >= 0; w--) begin
      do_move(1'b0, 1'b1);
      read_all("R3 downward sweep");
    end
    // R3: window 7 outgoing 10 wraps onto window 0 incoming 26
    rd_addr_a = 5'd26; #1;
    chk("R3 wrap 7->0", rd_data_a, pat(7, 10, 1));
    // R1: global 5 holds its last value from window 7
    rd_addr_a = 5'd5; #1;
    chk("R1 global shared", rd_data_a, pat(7, 5, 1));

    // R7: return with one live window refused
    do_move(1'b0, 1'b1);
    chk("R7 ptr held at 0", 32'(win_ptr), 32'd0);
    tick();
    chk("R11 unf drops", 32'(win_unf), 32'd0);

    // R5: call and return together
    do_move(1'b1, 1'b0);
    do_move(1'b1, 1'b1);
    chk("R5 both ignored", 32'(win_ptr), 32'd1);

    // R3: outgoing of window 1 seen as incoming of window 2
    do_write(12, 32'hCAFE_0012);
    do_move(1'b1, 1'b0);
    rd_addr_a = 5'd28; #1;
    chk("R3 out->in", rd_data_a, 32'hCAFE_0012);

    // R2: write to register 0 is ignored, all others unchanged
    do_write(0, 32'hFFFF_FFFF);
    rd_addr_a = 5'd0; #1;
    chk("R2 r0 zero", rd_data_a, 32'h0);
    read_all("R2 no side effect");

    // R8: write with call in same cycle uses old pointer (window 2)
    wr_en = 1'b1; wr_addr = 5'd20; wr_data = 32'hBEEF_0020;
    mdl[pmap(20, cwp_m)] = 32'hBEEF_0020;
    do_move(1'b1, 1'b0);
    wr_en = 1'b0;
    do_move(1'b0, 1'b1);
    rd_addr_a = 5'd20; #1;
    chk("R8 write old ptr", rd_data_a, 32'hBEEF_0020);
    // R8: same with return (window 2 -> 1)
    wr_en = 1'b1; wr_addr = 5'd17; wr_data = 32'hBEEF_0017;
    mdl[pmap(17, cwp_m)] = 32'hBEEF_0017;
    do_move(1'b0, 1'b1);
    wr_en = 1'b0;
    rd_addr_a = 5'd17; #1;
    chk("R8 ret new window differs", rd_data_a, mdl[pmap(17, 1)]);
    do_move(1'b1, 1'b0);
    rd_addr_a = 5'd17; #1;
    chk("R8 write old ptr ret", rd_data_a, 32'hBEEF_0017);

    // R9: no bypass during write cycle
    keep = mdl[pmap(22, cwp_m)];
    rd_addr_a = 5'd22;
    wr_en = 1'b1; wr_addr = 5'd22; wr_data = 32'h1111_2222;
    #1;
    chk("R9 old value while writing", rd_data_a, keep);
    tick();
    wr_en = 1'b0;
    mdl[pmap(22, cwp_m)] = 32'h1111_2222;
    chk("R9 new value after edge", rd_data_a, 32'h1111_2222);

    // R10: reset keeps contents, clears pointer and live count
    do_move(1'b0, 1'b1);
    do_move(1'b0, 1'b1);
    do_write(17, 32'h1234_5678);
    do_move(1'b1, 1'b0);
    do_move(1'b1, 1'b0);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    cwp_m = 0; live_m = 1;
    chk("R10 ptr cleared", 32'(win_ptr), 32'd0);
    rd_addr_a = 5'd17; #1;
    chk("R10 contents kept", rd_data_a, 32'h1234_5678);
    do_move(1'b0, 1'b1);
    chk("R10 live count cleared", 32'(win_unf), 32'd1);
    read_all("R10 full contents kept");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule